// File: doc/BRIEF.md
# I2C EEPROM Target with Block Select

This block is an I2C target that looks to a bus controller like a 512-byte serial EEPROM. It watches the SCL and SDA lines, which arrive already synchronized to the fast system clock. From those lines it recognizes START and STOP conditions and collects the control byte. It then decides whether to acknowledge and serves byte writes and sequential reads against an internal 512 x 8 storage array. SDA is handled as an open-drain line: the block never drives it high, it only asserts an output enable that pulls the line low.

The 9-bit memory address is split across two bytes. The word-address byte supplies the low eight bits. Bit 1 of the control byte supplies the ninth bit and so picks one of the two 256-byte halves. The chip-select pins found on similar parts are not used, and control bits 3..2 play no part in matching. Write-cycle programming time, page-buffer limits, clock stretching and arbitration are not modelled.

Top module: `i2c_blksel_mem`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts control-byte reception from any state, including in the middle of a transfer (repeated START).
- R2: The target acknowledges a control byte (drives sda_oe=1, pulling SDA low, during the ninth SCL high period) exactly when control bits 7..4 equal 4'b1010. Bits 3..2 are ignored. After a control byte that does not match, no byte is acknowledged until the next START.
- R3: Control bytes whose upper nibble is 4'b0000 or 4'b1111 (reserved 7-bit addresses 0000xxx and 1111xxx) are never acknowledged.
- R4: Control bit 1 becomes bit 8 of the memory address and selects the lower (0) or upper (1) 256-byte half for both reads and writes.
- R5: With control bit 0 = 0 (write), the first byte after the control byte loads address bits 7..0. Each further byte is stored at the current address and acknowledged, and address bits 7..0 then increment, wrapping from 0xFF to 0x00 while bit 8 is kept.
- R6: With control bit 0 = 1 (read), the target drives the byte at the current address MSB first, changing sda_oe only while SCL is low. It increments address bits 7..0 (wrapping within the half) after each byte, and sends the next byte when the controller acknowledges.
- R7: A NACK from the controller after a read byte ends the transfer: sda_oe stays 0 until the next START.
- R8: A STOP (SDA rising while SCL is high) returns the target to idle with sda_oe=0. Bytes clocked after it without a START are not acknowledged.
- R9: While rst_n is low at a clock edge, sda_oe is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |

## Verification
The bench targets the points where a design that is nearly right still goes wrong. A write that crosses 0xFF must wrap to offset 0x00 in the same half. A design that carries into bit 8 would corrupt the other half, and the bench catches this by reading back a byte placed in the lower half beforehand. Random reads use a repeated START, so a design that only resynchronizes on a START after a STOP misses the second control byte. Control bytes with don't-care bits set, reserved nibbles and foreign device codes check the address match in both directions. After a NACK, after a mismatch and after a STOP, the bench keeps clocking bytes and expects a silent line, which exposes a target that keeps driving or still acknowledges.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C EEPROM target.
// Assumes a byte-wide memory; the sequencer states and receive-phase kinds live here.
package i2cm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,    // waiting for START
        S_RX,      // shifting in a byte on SCL rising edges
        S_DECIDE,  // full byte held, act on next SCL fall
        S_ACK,     // target drives ACK through ninth clock
        S_RD,      // target drives a read byte
        S_RACK,    // controller answers ACK/NACK
        S_RLOAD,   // controller acked, load next byte on SCL fall
        S_IGNORE   // not addressed, wait for START or STOP
    } tgt_state_t;

    typedef enum logic [1:0] {
        K_CTRL,    // byte being received is the control byte
        K_WADDR,   // byte being received is the word address
        K_WDATA    // byte being received is write data
    } rx_kind_t;
endpackage

// File: rtl/i2cm_line_cond.sv
// Bus line condition detector.
// Keeps registered copies of SCL and SDA and compares them with the present
// levels to produce single-cycle SCL edge pulses and START/STOP pulses.
// Assumes both lines are already synchronized to clk and SCL phases last
// several clk cycles.
module i2cm_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Hold last-cycle line levels; idle bus reads high on both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Edge and condition pulses from present versus previous levels.
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2cm_bank.sv
// One 256-entry half of the target storage.
// Synchronous write, combinational read. Contents are not reset, as with a
// non-volatile array whose contents survive a reset.
module i2cm_bank #(
    parameter int DATA_W = 8,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte when the sequencer commits write data.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Read port used to load outgoing read bytes.
    assign rdata = mem[addr];
endmodule

// File: rtl/i2cm_proto.sv
// I2C target protocol sequencer.
// Receives bytes on SCL rising edges, decides on each SCL falling edge after
// the eighth bit, drives ACK and read data while SCL is low, and tracks the
// 9-bit memory pointer (upper bits from the control byte, lower from the
// word address). Assumes edge and condition pulses from i2cm_line_cond.
module i2cm_proto
    import i2cm_pkg::*;
#(
    parameter int         MEM_AW   = 9,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_oe
);
    localparam int BLK_W = MEM_AW - BYTE_W;

    tgt_state_t        state;
    rx_kind_t          kind;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [MEM_AW-1:0] addr;
    logic              rd_q;
    logic              ctrl_match;

    // Device code match with reserved address groups always refused.
    always_comb begin
        ctrl_match = (shreg[7:4] == DEV_CODE) &&
                     (shreg[7:4] != 4'b0000) && (shreg[7:4] != 4'b1111);
    end

    // Commit write data on the decision edge of a data byte.
    always_comb begin
        mem_we    = (state == S_DECIDE) && (kind == K_WDATA) && scl_fall &&
                    !start_det && !stop_det;
        mem_addr  = addr;
        mem_wdata = shreg;
    end

    // Main sequencer: conditions first, then per-state SCL edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            kind   <= K_CTRL;
            bitcnt <= 3'd0;
            shreg  <= '0;
            addr   <= '0;
            rd_q   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= S_RX;
            kind   <= K_CTRL;
            bitcnt <= 3'd0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                S_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_i};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            state <= S_DECIDE;
                        end
                    end
                end
                S_DECIDE: begin
                    if (scl_fall) begin
                        case (kind)
                            K_CTRL: begin
                                if (ctrl_match) begin
                                    addr[MEM_AW-1:BYTE_W] <= shreg[BLK_W:1];
                                    rd_q   <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= S_ACK;
                                end else begin
                                    state <= S_IGNORE;
                                end
                            end
                            K_WADDR: begin
                                addr[BYTE_W-1:0] <= shreg;
                                sda_oe <= 1'b1;
                                state  <= S_ACK;
                            end
                            K_WDATA: begin
                                addr[BYTE_W-1:0] <= addr[BYTE_W-1:0] + 8'd1;
                                sda_oe <= 1'b1;
                                state  <= S_ACK;
                            end
                            default: state <= S_IGNORE;
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= 3'd0;
                        if ((kind == K_CTRL) && rd_q) begin
                            shreg  <= mem_rdata;
                            sda_oe <= ~mem_rdata[BYTE_W-1];
                            state  <= S_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            kind   <= (kind == K_CTRL) ? K_WADDR : K_WDATA;
                            state  <= S_RX;
                        end
                    end
                end
                S_RD: begin
                    if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            addr[BYTE_W-1:0] <= addr[BYTE_W-1:0] + 8'd1;
                            state  <= S_RACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        state <= sda_i ? S_IGNORE : S_RLOAD;
                    end
                end
                S_RLOAD: begin
                    if (scl_fall) begin
                        bitcnt <= 3'd0;
                        shreg  <= mem_rdata;
                        sda_oe <= ~mem_rdata[BYTE_W-1];
                        state  <= S_RD;
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // START always lands in control-byte reception with SDA released.
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_RX && kind == K_CTRL && bitcnt == 3'd0 && !sda_oe)); // R1

    // A control byte with a foreign device code is not acknowledged.
    AST_FOREIGN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECIDE && kind == K_CTRL && scl_fall && !start_det && !stop_det &&
         shreg[7:4] != DEV_CODE) |=> (!sda_oe && state == S_IGNORE)); // R2

    // Reserved address groups go to the ignore state with SDA released.
    AST_RESERVED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECIDE && kind == K_CTRL && scl_fall && !start_det && !stop_det &&
         (shreg[7:4] == 4'b0000 || shreg[7:4] == 4'b1111)) |=> (!sda_oe && state == S_IGNORE)); // R3

    // The block-select bits only move when a control byte is decided.
    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == S_DECIDE && kind == K_CTRL) |=> $stable(addr[MEM_AW-1:BYTE_W])); // R4

    // A stored write byte advances the offset with wrap inside the block.
    AST_WRITE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr[BYTE_W-1:0] == $past(addr[BYTE_W-1:0]) + 8'd1 &&
                    $stable(addr[MEM_AW-1:BYTE_W]))); // R5

    // A controller NACK leaves the target silent.
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && scl_rise && sda_i && !start_det && !stop_det) |=>
        (state == S_IGNORE && !sda_oe)); // R7

    // STOP returns to idle with SDA released.
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE && !sda_oe)); // R8

    // Reset releases the line.
    AST_RESET_RELEASE: assert property (@(posedge clk)
        !rst_n |=> !sda_oe); // R9
endmodule

// File: rtl/i2c_blksel_mem.sv
// I2C EEPROM target with block select, top level.
// Joins the line detector, the protocol sequencer and the storage halves.
// The upper address bits, taken from the control byte, pick one generated
// 256-byte bank. Assumes scl_i/sda_i are synchronized to clk and that SCL
// phases span several clk cycles. sda_oe is an open-drain pull-low enable.
module i2c_blksel_mem
    import i2cm_pkg::*;
#(
    parameter int         MEM_AW   = 9,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int BLK_W = MEM_AW - BYTE_W;
    localparam int NBANK = 1 << BLK_W;

    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata;
    logic [BYTE_W-1:0] bank_rd [NBANK];

    i2cm_line_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cm_proto #(
        .MEM_AW   (MEM_AW),
        .DEV_CODE (DEV_CODE)
    ) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_i     (sda_i),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe)
    );

    // One storage half per block-select value.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        i2cm_bank #(
            .DATA_W (BYTE_W),
            .AW     (BYTE_W)
        ) u_bank (
            .clk   (clk),
            .we    (mem_we && (mem_addr[MEM_AW-1:BYTE_W] == BLK_W'(g))),
            .addr  (mem_addr[BYTE_W-1:0]),
            .wdata (mem_wdata),
            .rdata (bank_rd[g])
        );
    end

    // Read data comes from the bank chosen by the block-select bits.
    assign mem_rdata = bank_rd[mem_addr[MEM_AW-1:BYTE_W]];

    // The line may only change under the target while SCL is low.
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(start_det) && !$past(stop_det)) |->
        $stable(sda_oe)); // R6
endmodule

// File: tb/i2c_blksel_mem_bench.sv
// Self-checking bench: a control-byte table walked by one loop, then
// directed write/read, wrap, repeated-START, NACK, STOP and mismatch tests.
module i2c_blksel_mem_bench;
    localparam int CLK_P = 10;
    localparam int Q     = 4;   // clk cycles per quarter SCL period
    localparam int NTAB  = 11;

    // {control byte, expected acknowledge}
    localparam logic [8:0] CTRL_TAB [NTAB] = '{
        {8'hA0, 1'b1}, {8'hA2, 1'b1}, {8'hAC, 1'b1}, {8'hAE, 1'b1},
        {8'h00, 1'b0}, {8'h0E, 1'b0}, {8'hF0, 1'b0}, {8'hFE, 1'b0},
        {8'h50, 1'b0}, {8'hB0, 1'b0}, {8'h20, 1'b0}
    };

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic line;
    int   checks = 0;
    int   errors = 0;

    assign line = m_sda & ~sda_oe;

    always #(CLK_P / 2) clk = ~clk;

    i2c_blksel_mem u_i2c_blksel_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (line),
        .sda_oe (sda_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq(Q);
        scl   = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl   = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq(Q);
        scl   = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    // Send a byte MSB first; ack = 1 when the target pulled SDA low.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            scl   = 1'b1; wq(2 * Q);
            scl   = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        scl   = 1'b1; wq(Q);
        ack   = ~line; wq(Q);
        scl   = 1'b0; wq(Q);
    endtask

    // Clock in a byte, then answer with ACK (nack=0) or NACK (nack=1).
    task automatic recv_byte(input logic nack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl  = 1'b1; wq(Q);
            d[i] = line; wq(Q);
            scl  = 1'b0;
        end
        wq(Q);
        m_sda = nack; wq(Q);
        scl   = 1'b1; wq(2 * Q);
        scl   = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    // Set the pointer with a write control byte and word address, then restart in read.
    task automatic point_read(input logic [7:0] ctrl_w, input logic [7:0] wa);
        logic ack;
        i2c_start();
        send_byte(ctrl_w, ack);      check("R5 ctrl ack", ack, 1);
        send_byte(wa, ack);          check("R5 waddr ack", ack, 1);
        i2c_start();
        send_byte(ctrl_w | 8'h01, ack); check("R1 restart ack", ack, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;

        wq(4);
        check("R9 reset release", sda_oe, 0);
        rst_n = 1'b1;
        wq(4);
        check("R9 after reset", sda_oe, 0);

        // Control-byte table: R2 matches and don't-care bits, R3 reserved nibbles.
        for (int i = 0; i < NTAB; i++) begin
            i2c_start();
            send_byte(CTRL_TAB[i][8:1], ack);
            if (CTRL_TAB[i][8:5] == 4'h0 || CTRL_TAB[i][8:5] == 4'hF)
                check("R3 reserved", ack, CTRL_TAB[i][0]);
            else
                check("R2 match", ack, CTRL_TAB[i][0]);
            i2c_stop();
        end

        // Lower half writes at 0x010.
        i2c_start();
        send_byte(8'hA0, ack); check("R5 ctrl", ack, 1);
        send_byte(8'h10, ack); check("R5 waddr", ack, 1);
        send_byte(8'h11, ack); check("R5 data0", ack, 1);
        send_byte(8'h22, ack); check("R5 data1", ack, 1);
        send_byte(8'h33, ack); check("R5 data2", ack, 1);
        i2c_stop();

        // Upper half write at 0x110.
        i2c_start();
        send_byte(8'hA2, ack); check("R4 ctrl", ack, 1);
        send_byte(8'h10, ack); check("R4 waddr", ack, 1);
        send_byte(8'h99, ack); check("R4 data", ack, 1);
        i2c_stop();

        // Sequential read of the lower half through a repeated START.
        point_read(8'hA0, 8'h10);
        recv_byte(1'b0, d); check("R6 read0", d, 8'h11);
        recv_byte(1'b0, d); check("R6 read1", d, 8'h22);
        recv_byte(1'b1, d); check("R6 read2", d, 8'h33);
        i2c_stop();

        // Upper half keeps its own byte at the same offset.
        point_read(8'hA2, 8'h10);
        recv_byte(1'b1, d); check("R4 upper read", d, 8'h99);
        i2c_stop();

        // Control bits 3..2 set: still the upper half.
        i2c_start();
        send_byte(8'hAE, ack); check("R2 dont-care ctrl", ack, 1);
        send_byte(8'h40, ack); check("R2 dont-care waddr", ack, 1);
        send_byte(8'hC3, ack); check("R2 dont-care data", ack, 1);
        i2c_stop();
        point_read(8'hA2, 8'h40);
        recv_byte(1'b1, d); check("R4 dont-care readback", d, 8'hC3);
        i2c_stop();

        // Guard byte at lower-half 0x000, then a write across 0x1FF.
        i2c_start();
        send_byte(8'hA0, ack); send_byte(8'h00, ack);
        send_byte(8'hE1, ack); check("R5 guard write", ack, 1);
        i2c_stop();
        i2c_start();
        send_byte(8'hA2, ack); send_byte(8'hFE, ack);
        send_byte(8'h5A, ack); send_byte(8'h6B, ack);
        send_byte(8'h7C, ack); check("R5 wrap write ack", ack, 1);
        i2c_stop();
        point_read(8'hA2, 8'hFE);
        recv_byte(1'b0, d); check("R6 wrap read 1FE", d, 8'h5A);
        recv_byte(1'b0, d); check("R6 wrap read 1FF", d, 8'h6B);
        recv_byte(1'b1, d); check("R5 wrap landed 100", d, 8'h7C);
        // After the NACK the target must stay silent.
        recv_byte(1'b1, d); check("R7 silent after nack", d, 8'hFF);
        check("R7 released", sda_oe, 0);
        i2c_stop();
        point_read(8'hA0, 8'h00);
        recv_byte(1'b1, d); check("R5 lower half untouched", d, 8'hE1);
        i2c_stop();

        // STOP mid-write, then a byte without START.
        i2c_start();
        send_byte(8'hA0, ack); send_byte(8'h20, ack);
        i2c_stop();
        check("R8 released after stop", sda_oe, 0);
        send_byte(8'hA0, ack); check("R8 no ack without start", ack, 0);
        i2c_stop();

        // Mismatched device code: nothing acknowledged until START.
        i2c_start();
        send_byte(8'hB0, ack); check("R2 mismatch ctrl", ack, 0);
        send_byte(8'h00, ack); check("R2 ignored byte", ack, 0);
        send_byte(8'hA0, ack); check("R2 ignored match code", ack, 0);
        i2c_start();
        send_byte(8'hA0, ack); check("R1 start after ignore", ack, 1);
        i2c_stop();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule